// File: doc/BRIEF.md
# ECC Status and Erased-Page Checker

This block runs after a page has been read and its hardware ECC has produced a one-byte status. When the status shows a correctable page, the block forwards the corrected-bit count without looking at the data. When the status flags the page as uncorrectable, the block does not take that verdict as final. It scans the data and spare areas of the page, 32 bits per beat, and counts the bits that read as zero. A freshly erased page reads as all ones, and an erased page with only a few flipped cells still fails the ECC check. The block tells these two cases apart.

The threshold is half of the ECC correction strength. Once the running zero count passes the threshold, further words are no longer added, but the block still waits for the word that carries the last flag before it reports. Each report is a single-cycle done pulse that carries a 2-bit outcome code and a 7-bit count. On an erased outcome, the consumer replaces the whole page with 0xFF bytes. An uncorrectable outcome is recorded as a failed read.

Top module: `ecc_erase_checker`

## Requirements
- R1: After synchronous reset, `done_o` is low and the block waits for `start_i`.
- R2: When `start_i` is taken while idle and bit 7 of `status_i` is clear, `done_o` pulses in the next cycle with outcome code 2'b00 (corrected) and `count_o` equal to `status_i[5:0]`. Bit 6 has no effect and no words are scanned.
- R3: When `start_i` is taken while idle and `status_i[7]` is set, the block enters a scan. In each following cycle with `word_valid_i` high, it adds the number of zero bits of `word_data_i` (the population count of the inverted word) to a running total that starts at zero.
- R4: Once the running total exceeds the threshold `ECC_STRENGTH/2` (16 by default), later words add nothing to it.
- R5: During a scan, `done_o` stays low until a beat with both `word_valid_i` and `word_last_i` high. It pulses in the cycle right after that beat, and the total includes that beat's word if it was still being counted.
- R6: If the final total is at most the threshold, the outcome code is 2'b01 (erased, so the consumer substitutes all-ones data) and `count_o` is the total.
- R7: If the final total exceeds the threshold, the outcome code is 2'b10 (uncorrectable) and `count_o` is the total at the point the count stopped.
- R8: `start_i` during a scan, beats with `word_valid_i` low, and words presented while idle are all ignored. None of them changes the state or the total.
- R9: The outcome code 2'b11 is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin checking one page; taken only while idle |
| status_i | input | 8 | ECC status byte, sampled with `start_i` |
| word_valid_i | input | 1 | Word beat present on `word_data_i` |
| word_data_i | input | 32 | Page word (data area, then spare area) |
| word_last_i | input | 1 | Marks the final word of the page |
| done_o | output | 1 | One-cycle result pulse |
| outcome_o | output | 2 | 00 corrected, 01 erased, 10 uncorrectable |
| count_o | output | 7 | Corrected bits or zero-bit total |

## Verification
A correctable status gives its result exactly one cycle after the start cycle. A scan gives its result exactly one cycle after the beat that carries the last flag. Inputs change on the falling edge, so the bench reads `done_o`, `outcome_o` and `count_o` at the first falling edge after the rising edge that registers them. On every intermediate beat of a scan it also confirms that `done_o` is still low. The falling edge after each pulse is checked for `done_o` low again, which catches a stretched or repeated pulse. Expected outcomes and counts come from a bench model of the threshold rule. That model applies the early stop word by word, so a design that keeps counting past the threshold reports a different total.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

    // Status byte layout; the ECC engine upstream writes these positions.
    localparam int STAT_UNCORR_BIT = 7;
    localparam int STAT_CNT_MSB    = 5;
    localparam int STAT_CNT_W      = STAT_CNT_MSB + 1;

    typedef enum logic [1:0] {
        OUTC_CORRECTED = 2'b00,
        OUTC_ERASED    = 2'b01,
        OUTC_UNCORR    = 2'b10
    } outcome_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    typedef struct packed {
        logic                  uncorr;
        logic [STAT_CNT_W-1:0] corr_cnt;
    } ecc_stat_t;

    function automatic ecc_stat_t decode_status(input logic [7:0] raw);
        ecc_stat_t s;
        s.uncorr   = raw[STAT_UNCORR_BIT];
        s.corr_cnt = raw[STAT_CNT_MSB:0];
        return s;
    endfunction

endpackage

// File: rtl/ecs_zero_pop.sv
module ecs_zero_pop #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = WORD_W / LANE_W,
    localparam int LC_W  = $clog2(LANE_W + 1),
    localparam int PC_W  = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [PC_W-1:0]   zeros_o
);

    logic [LANES*LC_W-1:0] lane_cnt;

    // Count the zero bits in each lane independently, then sum the lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LC_W-1:0] cnt;
        always_comb begin
            cnt = '0;
            for (int b = 0; b < LANE_W; b++) begin
                cnt = cnt + LC_W'(~word_i[g*LANE_W + b]);
            end
        end
        assign lane_cnt[g*LC_W +: LC_W] = cnt;
    end

    always_comb begin
        zeros_o = '0;
        for (int l = 0; l < LANES; l++) begin
            zeros_o = zeros_o + PC_W'(lane_cnt[l*LC_W +: LC_W]);
        end
    end

endmodule

// File: rtl/ecs_accum.sv
module ecs_accum #(
    parameter int CNT_W  = 7,
    parameter int PC_W   = 6,
    parameter int THRESH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             add_en_i,
    input  logic [PC_W-1:0]  add_val_i,
    output logic [CNT_W-1:0] acc_o,
    output logic [CNT_W-1:0] acc_next_o,
    output logic             over_o
);

    logic [CNT_W-1:0] acc_q;
    logic             take;

    assign over_o     = acc_q > CNT_W'(THRESH);
    assign take       = add_en_i && !over_o;
    assign acc_next_o = take ? acc_q + CNT_W'(add_val_i) : acc_q;
    assign acc_o      = acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) acc_q <= '0;
        else              acc_q <= acc_next_o;
    end

    // R4: once past the threshold the total is frozen until cleared
    p_stop_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (over_o && !clr_i) |=> $stable(acc_q));

    // R8: a cycle with no add request leaves the total alone
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!add_en_i && !clr_i) |=> $stable(acc_q));

endmodule

// File: rtl/ecc_erase_checker.sv
module ecc_erase_checker #(
    parameter int WORD_W       = 32,
    parameter int LANE_W       = 8,
    parameter int ECC_STRENGTH = 32,
    parameter int CNT_W        = 7,
    localparam int THRESH = ECC_STRENGTH / 2,
    localparam int PC_W   = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [7:0]        status_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_data_i,
    input  logic              word_last_i,
    output logic              done_o,
    output logic [1:0]        outcome_o,
    output logic [CNT_W-1:0]  count_o
);
    import ecs_pkg::*;

    scan_state_e      state_q;
    ecc_stat_t        stat;
    logic             take_start;
    logic             beat;
    logic             last_beat;
    logic [PC_W-1:0]  zeros;
    logic [CNT_W-1:0] acc, acc_next;
    logic             over;
    logic             done_q;
    outcome_e         code_q;
    logic [CNT_W-1:0] cnt_q;

    assign stat       = decode_status(status_i);
    assign take_start = (state_q == ST_IDLE) && start_i;
    assign beat       = (state_q == ST_SCAN) && word_valid_i;
    assign last_beat  = beat && word_last_i;

    ecs_zero_pop #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_pop (
        .word_i  (word_data_i),
        .zeros_o (zeros)
    );

    ecs_accum #(.CNT_W(CNT_W), .PC_W(PC_W), .THRESH(THRESH)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (take_start),
        .add_en_i   (beat),
        .add_val_i  (zeros),
        .acc_o      (acc),
        .acc_next_o (acc_next),
        .over_o     (over)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            code_q  <= OUTC_CORRECTED;
            cnt_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take_start) begin
                        if (stat.uncorr) begin
                            state_q <= ST_SCAN;
                        end else begin
                            done_q <= 1'b1;
                            code_q <= OUTC_CORRECTED;
                            cnt_q  <= CNT_W'(stat.corr_cnt);
                        end
                    end
                end
                ST_SCAN: begin
                    if (last_beat) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        cnt_q   <= acc_next;
                        code_q  <= (acc_next > CNT_W'(THRESH)) ? OUTC_UNCORR
                                                               : OUTC_ERASED;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o    = done_q;
    assign outcome_o = code_q;
    assign count_o   = cnt_q;

    // R2: correctable status answers in the following cycle with its count
    p_fast_corr_r2: assert property (@(posedge clk) disable iff (rst)
        (take_start && !status_i[7]) |=>
            (done_o && outcome_o == OUTC_CORRECTED &&
             count_o == CNT_W'($past(status_i[5:0]))));

    // R5: no result while a scan waits for its last word
    p_no_early_done_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && !last_beat) |=> !done_o);

    // R5: last beat of a scan produces the pulse next cycle
    p_last_done_r5: assert property (@(posedge clk) disable iff (rst)
        last_beat |=> (done_o && state_q == ST_IDLE));

    // R6: an erased verdict never carries a total above the threshold
    p_erased_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (done_o && outcome_o == OUTC_ERASED) |-> (count_o <= CNT_W'(THRESH)));

    // R7: an uncorrectable verdict always carries a total above the threshold
    p_uncorr_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && outcome_o == OUTC_UNCORR) |-> (count_o > CNT_W'(THRESH)));

    // R8: start during a scan does not restart or end it
    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && start_i && !last_beat) |=> (state_q == ST_SCAN));

    // R9: the spare outcome code never appears
    p_legal_code_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (outcome_o != 2'b11));

endmodule

// File: tb/test_ecc_erase_checker.sv
module test_ecc_erase_checker;

    localparam int STRENGTH = 32;
    localparam int THR      = STRENGTH / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  status_i = 8'h00;
    logic        word_valid_i = 1'b0;
    logic [31:0] word_data_i = 32'hFFFF_FFFF;
    logic        word_last_i = 1'b0;
    logic        done_o;
    logic [1:0]  outcome_o;
    logic [6:0]  count_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [31:0] pg [16];

    always #2.5 clk = ~clk;

    ecc_erase_checker #(.ECC_STRENGTH(STRENGTH)) i_ecc_erase_checker (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .status_i     (status_i),
        .word_valid_i (word_valid_i),
        .word_data_i  (word_data_i),
        .word_last_i  (word_last_i),
        .done_o       (done_o),
        .outcome_o    (outcome_o),
        .count_o      (count_o)
    );

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: act=%0d exp<=20000 cycles", cycles);
            summary_and_end();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Scenario: status with bit 7 clear answers at once (R2)
    task automatic t_corrected(input logic [7:0] st, input bit words_too);
        @(negedge clk);
        start_i = 1'b1; status_i = st;
        if (words_too) begin
            word_valid_i = 1'b1; word_data_i = 32'h0; word_last_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0; word_valid_i = 1'b0; word_last_i = 1'b0;
        chk("R2 done", done_o, 1);
        chk("R2 outcome", outcome_o, 0);
        chk("R2 count", count_o, st[5:0]);
        chk("R9 code", int'(outcome_o != 2'b11), 1);
        @(negedge clk);
        chk("R2 single pulse", done_o, 0);
    endtask

    // Scenario: scan of n words held in pg (R3..R8)
    task automatic t_scan(input int n, input bit gaps, input bit noise, input string tag);
        int acc = 0;
        int exp_code;
        for (int i = 0; i < n; i++)
            if (acc <= THR) acc += $countones(~pg[i]);
        exp_code = (acc > THR) ? 2 : 1;
        @(negedge clk);
        start_i = 1'b1; status_i = 8'h80;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                word_valid_i = 1'b0; word_data_i = 32'h0; word_last_i = 1'b1;
                @(negedge clk);
                chk({tag, " R8 gap no done"}, done_o, 0);
            end
            word_valid_i = 1'b1; word_data_i = pg[i]; word_last_i = (i == n - 1);
            if (noise && i == 0) begin
                start_i = 1'b1; status_i = 8'h05;
            end
            @(negedge clk);
            start_i = 1'b0;
            if (i != n - 1) chk({tag, " R5 no done before last"}, done_o, 0);
        end
        word_valid_i = 1'b0; word_last_i = 1'b0; word_data_i = 32'hFFFF_FFFF;
        chk({tag, " R5 done after last"}, done_o, 1);
        chk({tag, " R6/R7 outcome"}, outcome_o, exp_code);
        chk({tag, " R6/R7 count"}, count_o, acc);
        chk({tag, " R9 code"}, int'(outcome_o != 2'b11), 1);
        @(negedge clk);
        chk({tag, " R5 single pulse"}, done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset done low", done_o, 0);

        t_corrected(8'h05, 1'b0);
        t_corrected(8'h3F, 1'b0);
        t_corrected(8'h47, 1'b1);     // R2: bit 6 ignored, words ignored

        // R8: words while idle are not counted and do not finish anything
        for (int k = 0; k < 3; k++) begin
            word_valid_i = 1'b1; word_data_i = 32'h0; word_last_i = 1'b1;
            @(negedge clk);
            chk("R8 idle words no done", done_o, 0);
        end
        word_valid_i = 1'b0; word_last_i = 1'b0;

        // R3/R6: clean erased page
        for (int i = 0; i < 8; i++) pg[i] = 32'hFFFF_FFFF;
        t_scan(8, 1'b0, 1'b0, "erased0");

        // R6 boundary: total exactly at threshold
        for (int i = 0; i < 4; i++) pg[i] = 32'hFFFF_FFF0;
        pg[4] = 32'hFFFF_FFFF;
        t_scan(5, 1'b0, 1'b0, "at_thr");

        // R7 boundary: one above threshold, then more zeros ignored (R4)
        for (int i = 0; i < 4; i++) pg[i] = 32'hFFFF_FFF0;
        pg[4] = 32'hFFFF_FFFE;
        pg[5] = 32'h0000_0000;
        pg[6] = 32'h00FF_00FF;
        t_scan(7, 1'b0, 1'b0, "thr_plus1");

        // R4: early stop on a full-zero first word
        pg[0] = 32'h0000_0000;
        pg[1] = 32'h0000_FFFF;
        pg[2] = 32'h0F0F_0F0F;
        t_scan(3, 1'b0, 1'b0, "early_stop");

        // R8: valid gaps and a start during the scan are ignored
        pg[0] = 32'h7FFF_FFFF;
        pg[1] = 32'hFFFE_FFFF;
        pg[2] = 32'hFFFF_FFFF;
        pg[3] = 32'hEFFF_FFF7;
        t_scan(4, 1'b1, 1'b1, "gaps_noise");

        // R3: single-word page with scattered zeros
        pg[0] = 32'hA5A5_FFFF;
        t_scan(1, 1'b0, 1'b0, "one_word");

        // back-to-back correctable after a scan
        t_corrected(8'h80 ^ 8'h80 | 8'h0C, 1'b0);

        summary_and_end();
    end

endmodule